// File: doc/BRIEF.md
# DDR SDRAM Refresh Sequencer

This block keeps a four-bank DDR SDRAM refreshed for a memory controller. A free-running interval timer adds one refresh to a debt counter each time it expires, and the debt saturates at eight. The block asks an external arbiter for the command bus in two cases: when the debt is non-zero and the arbiter reports idle, or urgently when the debt is full. Once granted, it closes every bank with a precharge-all, waits the precharge time, and issues auto refresh commands back to back. Each refresh is followed by the full refresh cycle time before the next command. It keeps issuing them until the debt is paid or eight have gone out.

A low-power request takes the same route to the bus. After the precharge it places the device in self refresh with the clock enable held low, and keeps it there while the request stays high. When the request drops, the block runs the exit sequence. It drives one NOP cycle with the clock enable still low, then raises the clock enable under NOP and waits the exit-to-command time. It then issues a mandatory auto refresh and keeps the bus until the DLL-lock window has passed. While any of this is under way, a busy output stays high and every cycle without a command carries a NOP.

Top module: `ddr_refresh_seq`

## Requirements
- R1: Command pins {cs_n,ras_n,cas_n,we_n} are 0111 for NOP, 0010 for precharge-all and 0001 for auto refresh (cke high) or self-refresh entry (cke low). A precharge drives only address bit 10 high. Every other command drives the address to zero, and bank pins are always zero.
- R2: Every T_REFI cycles outside self-refresh mode the refresh debt rises by one, and it never exceeds eight.
- R3: In idle with a debt of eight, `urgent` and `req` are both high.
- R4: In idle, `req` is high when `sr_req` is high, when the debt is eight, or when the debt is non-zero and `arb_idle` is high. `req` with `grant` at a clock edge makes `busy` high from the next cycle until the sequence ends. At other times `grant` has no effect.
- R5: A granted sequence starts with a precharge-all, and the first command after it follows exactly T_RP cycles later.
- R6: Auto refreshes are T_RFC cycles apart and continue while the debt is non-zero, at most eight per grant. `busy` falls T_RFC cycles after the last one.
- R7: While `busy` is high, every cycle without a command drives NOP.
- R8: A grant with `sr_req` high gives precharge-all, then T_RP cycles later a self-refresh entry with cke low.
- R9: In self refresh, cke stays low, pins show NOP and no command is issued, whatever `grant` and `arb_idle` do.
- R10: When `sr_req` falls, one NOP cycle with cke low follows, then cke rises under NOP. Exactly T_XSNR cycles after the rise one auto refresh is issued, and `busy` falls max(T_XSRD, T_XSNR+T_RFC) cycles after the rise.
- R11: The debt is cleared by self-refresh mode. The first interval expiry comes T_REFI cycles after `busy` falls at exit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sr_req | input | 1 | Low-power request: enter and hold self refresh |
| arb_idle | input | 1 | Arbiter has no other traffic pending |
| grant | input | 1 | Arbiter hands the command bus to this block |
| req | output | 1 | Bus request to the arbiter |
| urgent | output | 1 | Refresh debt is full; must be served ahead of traffic |
| busy | output | 1 | A refresh or self-refresh sequence owns the bus |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| addr | output | ADDR_W | Address pins |
| ba | output | BANK_W | Bank address pins |

## Verification
Several rules are checked by assertions on every cycle. The debt never passes eight, and urgency implies a request. Busy only starts after a granted request. Every refresh keeps its distance from a preceding precharge or refresh. A falling clock enable coincides with a self-refresh entry, and a rising one happens under NOP after a NOP. Other behaviour needs the bench's scenarios to show it. These are the exact refresh count of a saturated burst and the idle-input blindness during self refresh. They also cover the exit timing up to the DLL-lock window and the clearing of the debt, which is seen as a full interval before the next request.

// File: rtl/ddr_refresh_seq.sv
module ddr_refresh_seq #(
  parameter int T_REFI   = 1560,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 12,
  parameter int T_XSNR   = 14,
  parameter int T_XSRD   = 200,
  parameter int MAX_OWED = 8,
  parameter int ADDR_W   = 13,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sr_req,
  input  logic              arb_idle,
  input  logic              grant,
  output logic              req,
  output logic              urgent,
  output logic              busy,
  output logic              cke,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [ADDR_W-1:0] addr,
  output logic [BANK_W-1:0] ba
);

  localparam int IW   = (T_REFI > 1) ? $clog2(T_REFI) : 1;
  localparam int TMAX = (T_RP > T_RFC) ? ((T_RP > T_XSNR) ? T_RP : T_XSNR)
                                       : ((T_RFC > T_XSNR) ? T_RFC : T_XSNR);
  localparam int TW   = $clog2(TMAX + 1);
  localparam int XW   = $clog2(T_XSRD + 1);
  localparam int OW   = $clog2(MAX_OWED + 1);
  localparam logic [OW:0] OMAX = (OW+1)'(MAX_OWED);

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_TRP, S_REF, S_TRFC, S_SRE, S_SR, S_SRXN, S_SRXW
  } st_t;

  st_t            st;
  logic [TW-1:0]  tmr;
  logic [IW-1:0]  icnt;
  logic [OW-1:0]  owed, bcnt;
  logic [XW-1:0]  xcnt;
  logic           srm;
  logic [OW:0]    sum;

  wire tick = !srm && (icnt == IW'(T_REFI - 1));
  wire dec  = (st == S_REF) && !srm;
  wire idle = (st == S_IDLE);

  assign urgent = idle && ({1'b0, owed} == OMAX);
  assign req    = idle && (sr_req || urgent || (owed != '0 && arb_idle));
  assign busy   = !idle;
  assign ba     = '0;
  assign sum    = {1'b0, owed} + (OW+1)'(tick) - (OW+1)'(dec);

  always_comb begin
    {cs_n, ras_n, cas_n, we_n} = 4'b0111;
    cke  = 1'b1;
    addr = '0;
    case (st)
      S_PRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0010; addr = ADDR_W'(1 << 10); end
      S_REF: {cs_n, ras_n, cas_n, we_n} = 4'b0001;
      S_SRE: begin {cs_n, ras_n, cas_n, we_n} = 4'b0001; cke = 1'b0; end
      S_SR, S_SRXN: cke = 1'b0;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      icnt <= '0;
      owed <= '0;
      xcnt <= '0;
    end else begin
      icnt <= (srm || tick) ? '0 : icnt + 1'b1;
      owed <= srm ? '0 : ((sum > OMAX) ? OMAX[OW-1:0] : sum[OW-1:0]);
      if (st == S_SRXN)    xcnt <= XW'(T_XSRD - 1);
      else if (xcnt != '0) xcnt <= xcnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tmr  <= '0;
      bcnt <= '0;
      srm  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req && grant) begin
          st <= S_PRE; srm <= sr_req; bcnt <= '0;
        end
        S_PRE: begin st <= S_TRP; tmr <= TW'(T_RP - 1); end
        S_TRP: if (tmr <= TW'(1)) st <= srm ? S_SRE : S_REF;
               else tmr <= tmr - 1'b1;
        S_REF: begin st <= S_TRFC; tmr <= TW'(T_RFC - 1); bcnt <= bcnt + 1'b1; end
        S_TRFC: if (tmr > TW'(1)) tmr <= tmr - 1'b1;
                else if (srm) begin
                  if (xcnt == '0) begin st <= S_IDLE; srm <= 1'b0; end
                end else if (owed != '0 && bcnt < OW'(MAX_OWED)) st <= S_REF;
                else st <= S_IDLE;
        S_SRE:  st <= S_SR;
        S_SR:   if (!sr_req) st <= S_SRXN;
        S_SRXN: begin st <= S_SRXW; tmr <= TW'(T_XSNR); end
        S_SRXW: if (tmr <= TW'(1)) st <= S_REF;
                else tmr <= tmr - 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  wire [3:0] pins   = {cs_n, ras_n, cas_n, we_n};
  wire       is_nop = (pins == 4'b0111);
  wire       is_pre = (pins == 4'b0010);
  wire       is_ref = (pins == 4'b0001) && cke;
  wire       is_sre = (pins == 4'b0001) && !cke;
  logic [15:0] gap;
  logic [1:0]  last_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap <= 16'hFFFF; last_kind <= 2'd0;
    end else if (!is_nop) begin
      gap <= 16'd1;
      last_kind <= is_pre ? 2'd1 : (is_ref ? 2'd2 : 2'd3);
    end else if (gap != 16'hFFFF) gap <= gap + 16'd1;
  end

  p_owed_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, owed} <= OMAX);
  p_urgent_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    urgent |-> req);
  p_busy_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && grant));
  p_rp_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_kind == 2'd1) |-> gap >= 16'(T_RP));
  p_rfc_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_ref && last_kind == 2'd2) |-> gap >= 16'(T_RFC));
  p_nop_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !is_pre && !is_ref && !is_sre) |-> is_nop);
  p_sre_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cke) |-> is_sre);
  p_sr_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> busy);
  p_exit_nop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cke) |-> (is_nop && $past(is_nop)));

endmodule

// File: tb/ddr_refresh_seq_test.sv
`timescale 1ns/1ps
module ddr_refresh_seq_test;
  localparam int T_REFI = 40, T_RP = 3, T_RFC = 6, T_XSNR = 8, T_XSRD = 20;
  localparam int MAXO = 8, ADDR_W = 13, BANK_W = 2;
  localparam int C_NOP = 0, C_PRE = 1, C_REF = 2, C_SRE = 3, C_LOW = 4, C_IDLE = 5;

  logic clk = 0, rst_n = 0, sr_req = 0, arb_idle = 0, grant = 0;
  logic req, urgent, busy, cke, cs_n, ras_n, cas_n, we_n;
  logic [ADDR_W-1:0] addr;
  logic [BANK_W-1:0] ba;

  ddr_refresh_seq #(.T_REFI(T_REFI), .T_RP(T_RP), .T_RFC(T_RFC), .T_XSNR(T_XSNR),
    .T_XSRD(T_XSRD), .MAX_OWED(MAXO), .ADDR_W(ADDR_W), .BANK_W(BANK_W)) uut (
    .clk(clk), .rst_n(rst_n), .sr_req(sr_req), .arb_idle(arb_idle), .grant(grant),
    .req(req), .urgent(urgent), .busy(busy), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .addr(addr), .ba(ba));

  always #2 clk = ~clk;

  int vectors = 0, miss = 0, cyc = 0, ref_cnt = 0, bad_nop = 0, bad_addr = 0;
  bit done = 0;
  int q[$];
  int cur = C_IDLE, ph = 0, owed_m = 0, icnt_m = 0, refs_m = 0;
  bit m_sr = 0, req_old, was_ref, was_sr, tick_old, exp_req, exp_urg;
  int exp_pins, exp_busy, exp_cke, exp_addr;
  string tag;

  task automatic chk(bit ok, string t, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: got %0d expected %0d", t, what, act, exp);
    end
  endtask

  task automatic push_n(int code, int n);
    for (int i = 0; i < n; i++) q.push_back(code);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); cur = C_IDLE; ph = 0; m_sr = 0; owed_m = 0; icnt_m = 0; refs_m = 0;
    end else begin
      req_old  = (ph == 0) && (sr_req || owed_m >= MAXO || (owed_m > 0 && arb_idle));
      was_ref  = (cur == C_REF) && !m_sr;
      was_sr   = m_sr;
      tick_old = !m_sr && (icnt_m == T_REFI - 1);
      case (ph)
        0: if (req_old && grant) begin
             m_sr = sr_req; refs_m = 0;
             q.push_back(C_PRE); push_n(C_NOP, T_RP - 1);
             if (m_sr) begin q.push_back(C_SRE); ph = 2; end
             else begin q.push_back(C_REF); push_n(C_NOP, T_RFC - 1); refs_m = 1; ph = 1; end
           end
        1: if (q.size() == 0) begin
             if (owed_m > 0 && refs_m < MAXO) begin
               q.push_back(C_REF); push_n(C_NOP, T_RFC - 1); refs_m++;
             end else ph = 0;
           end
        2: if (q.size() == 0) ph = 3;
        3: if (!sr_req) begin
             q.push_back(C_LOW); push_n(C_NOP, T_XSNR);
             q.push_back(C_REF); push_n(C_NOP, T_RFC - 1);
             while (q.size() < 1 + T_XSRD) q.push_back(C_NOP);
             ph = 4;
           end
        default: if (q.size() == 0) begin ph = 0; m_sr = 0; end
      endcase
      if (q.size() > 0) cur = q.pop_front();
      else cur = (ph == 3) ? C_LOW : C_IDLE;
      if (was_sr) begin icnt_m = 0; owed_m = 0; end
      else begin
        icnt_m = tick_old ? 0 : icnt_m + 1;
        owed_m = owed_m + int'(tick_old) - int'(was_ref);
        if (owed_m > MAXO) owed_m = MAXO;
      end
    end
    #1;
    exp_busy = (cur != C_IDLE); exp_cke = 1; exp_pins = 4'b0111; exp_addr = 0; tag = "R7";
    case (cur)
      C_PRE: begin exp_pins = 4'b0010; exp_addr = 1 << 10; tag = "R5"; end
      C_REF: begin exp_pins = 4'b0001; tag = "R6"; end
      C_SRE: begin exp_pins = 4'b0001; exp_cke = 0; tag = "R8"; end
      C_LOW: begin exp_cke = 0; tag = "R9"; end
      default: ;
    endcase
    exp_urg = (ph == 0) && (owed_m == MAXO);
    exp_req = (ph == 0) && (sr_req || exp_urg || (owed_m > 0 && arb_idle));
    chk({cs_n, ras_n, cas_n, we_n} == exp_pins[3:0], tag, "cmd pins",
        {cs_n, ras_n, cas_n, we_n}, exp_pins);
    chk(cke == exp_cke[0], (cur == C_LOW || cur == C_SRE) ? "R9" : "R10", "cke", cke, exp_cke);
    chk(busy == exp_busy[0], "R4", "busy", busy, exp_busy);
    chk(req == exp_req, "R4", "req", req, exp_req);
    chk(urgent == exp_urg, "R3", "urgent", urgent, exp_urg);
    chk(int'(addr) == exp_addr && ba == '0, "R1", "addr", int'(addr), exp_addr);
    if ({cs_n, ras_n, cas_n, we_n} == 4'b0001 && cke) begin
      ref_cnt++;
      if (addr != '0) bad_addr++;
    end
    if (busy && !({cs_n, ras_n, cas_n, we_n} inside {4'b0111, 4'b0010, 4'b0001})) bad_nop++;
  end

  task automatic wait_req();
    for (int i = 0; i < 3000 && !req; i++) @(negedge clk);
  endtask
  task automatic pulse_grant();
    wait_req();
    grant = 1;
    @(negedge clk);
    grant = 0;
    chk(busy == 1'b1, "R4", "busy after grant", busy, 1);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0010 && addr == ADDR_W'(1 << 10), "R5",
        "precharge first", {cs_n, ras_n, cas_n, we_n}, 4'b0010);
  endtask
  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miss++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end

  int base, c_rise, c_idle;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(busy == 0 && cke == 1 && req == 0, "R1", "reset state", busy, 0);
    // R2/R6: one expiry, opportunistic refresh
    arb_idle = 1;
    base = ref_cnt;
    pulse_grant();
    wait_idle();
    chk(ref_cnt - base == 1, "R6", "single refresh", ref_cnt - base, 1);
    // R2/R3: saturated debt, burst of eight
    arb_idle = 0;
    repeat (10 * T_REFI) @(negedge clk);
    chk(urgent == 1 && req == 1, "R3", "urgent at full debt", urgent, 1);
    base = ref_cnt;
    pulse_grant();
    wait_idle();
    chk(ref_cnt - base == MAXO, "R2", "burst count", ref_cnt - base, MAXO);
    chk(bad_addr == 0, "R1", "refresh address nonzero", bad_addr, 0);
    // R8..R11: self refresh
    sr_req = 1;
    pulse_grant();
    for (int i = 0; i < 20 && cke; i++) @(negedge clk);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0001 && !cke, "R8", "self refresh entry",
        {cs_n, ras_n, cas_n, we_n}, 1);
    base = ref_cnt;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      grant = i[0];
      arb_idle = ~arb_idle;
      chk(cke == 0 && busy == 1, "R9", "held in self refresh", cke, 0);
    end
    grant = 0; arb_idle = 1;
    @(negedge clk);
    chk(ref_cnt == base, "R9", "no command in self refresh", ref_cnt - base, 0);
    sr_req = 0;
    for (int i = 0; i < 50 && !cke; i++) @(negedge clk);
    c_rise = cyc;
    wait_idle();
    chk(cyc - c_rise == T_XSRD, "R10", "exit hold cycles", cyc - c_rise, T_XSRD);
    chk(ref_cnt - base == 1, "R10", "exit refresh count", ref_cnt - base, 1);
    c_idle = cyc;
    wait_req();
    chk(cyc - c_idle == T_REFI, "R11", "first expiry after exit", cyc - c_idle, T_REFI);
    base = ref_cnt;
    pulse_grant();
    wait_idle();
    chk(ref_cnt - base == 1, "R11", "debt cleared by self refresh", ref_cnt - base, 1);
    chk(bad_nop == 0, "R7", "non-NOP filler", bad_nop, 0);
    repeat (5) @(negedge clk);
    done = 1;
    report();
    $finish;
  end
endmodule